// File: doc/BRIEF.md
# Addressed SPI Master with Command Prebuffer

This block is an SPI master in clock mode 0 that is driven from a small bus register window of ten offsets. A bus access to offsets 0 through 7 starts one SPI frame to one of eight slaves. The low three bits of the offset drive three slave-address pins, which an external decoder can use. A single active-low chip select covers the whole frame. Before such an access, software may queue up to six command bytes by writing offset 8. The frame shifts out the queued bytes, oldest first, and then the final phase runs.

On a bus write, the final phase shifts out the written byte. On a bus read, the final phase drives MOSI low and clocks in the reply, either one byte or a 16-bit word. Word mode is enabled by bit 0 of the configuration register at offset 9. In word mode the reply's low byte is returned by the read and its high byte is kept for a later read of offset 8. While a frame is running, `bus_ready` is low and the block ignores further bus strobes.

Sequencing is handled by one state machine with these states:
- ST_IDLE: the block decodes strobes.
- ST_SETUP: the address pins settle for one SCLK half-period. The state exits when chip select falls.
- ST_LOAD: the next byte is taken from the queue, or the final byte or reply slot is loaded.
- ST_SHIFT: eight SCLK cycles are run.
- ST_HOLD: one half-period elapses, then chip select rises.
- ST_RELEASE: the address pins are held for one more half-period, the queue is cleared, and the state returns to ST_IDLE.

The transitions are:
- IDLE→SETUP on a strobe to offsets 0 to 7.
- SETUP→LOAD on a tick.
- LOAD→SHIFT always.
- SHIFT→LOAD when more bytes remain.
- SHIFT→HOLD after the final byte.
- HOLD→RELEASE on a tick.
- RELEASE→IDLE on a tick.

Top module: `spi_pkt_master`

## Requirements
- R1: A strobe with `bus_addr` in 0..7 while `bus_ready` is high starts a frame. `spi_sa` equals `bus_addr[2:0]` for the whole time `bus_ready` is low. `spi_cs_n` stays high whenever `bus_ready` is high.
- R2: The SPI protocol is mode 0. `spi_sclk` is low whenever `spi_cs_n` is high. MOSI changes only while SCLK is low. MISO is sampled on the rising SCLK edge. Bytes go MSB first.
- R3: Each SCLK half-period is HALF = CLK_HZ/(2*SCLK_HZ) clock cycles. With the defaults (50 MHz and 5 MHz) this is 5 cycles, and every SCLK high phase lasts exactly HALF cycles.
- R4: A write to offset 8 appends its byte to a six-entry queue. A write to offset 8 while the queue holds six bytes is dropped.
- R5: A write to offset 0..7 sends, in one chip-select frame, all queued bytes oldest first and then the written byte.
- R6: A read of offset 0..7 sends all queued bytes and then clocks in the reply while MOSI is held at 0. `bus_rdata` carries the reply's low byte once `bus_ready` returns high.
- R7: The queue is empty after every frame. A following frame carries no leftover command bytes.
- R8: A write to offset 9 sets word mode from `bus_wdata[0]`. Word mode is off after reset, so a read frame then has exactly one reply byte.
- R9: In word mode a read frame clocks in two reply bytes. The first byte received is the high byte, and a read of offset 8 returns it. The second byte is returned as the low byte.
- R10: Chip select falls no earlier than HALF cycles after `spi_sa` takes its new value. `bus_ready` returns high no earlier than HALF cycles after chip select rises.
- R11: Strobes that arrive while `bus_ready` is low have no effect. This covers queue pushes as well as frame starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | One-cycle access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register offset 0..9 |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while `bus_ready` is high after an access |
| bus_ready | output | 1 | High when idle; low while a frame runs |
| spi_sclk | output | 1 | SPI clock, idle low |
| spi_mosi | output | 1 | Master data out |
| spi_miso | input | 1 | Slave data in |
| spi_cs_n | output | 1 | Active-low chip select for the whole frame |
| spi_sa | output | 3 | Slave address taken from the accessed offset |

## Verification
The bench goes after these corner cases:
- **Full queue.** A push to a full queue must be dropped. A design that accepts it would send an eighth byte or overwrite the oldest one.
- **Queue reuse.** A frame issued right after a queued one must carry no command bytes. A design that does not clear the queue would resend stale commands.
- **Word mode.** Word mode must take the high byte first. A design with the order swapped would return the bytes exchanged at offsets 0..7 and offset 8. The bench also checks that the block starts with word mode off.
- **Busy strobes.** Strobes during a busy frame must be ignored. A design that accepts them would add bytes to the next frame or corrupt `spi_sa`.
- **Pin timing.** Every clock, the bench checks the address setup and hold around chip select, the exact SCLK high time, and that MOSI is low in the reply phase.

// File: rtl/spi_pkt_pkg.sv
package spi_pkt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_LOAD,
        ST_SHIFT,
        ST_HOLD,
        ST_RELEASE
    } pkt_state_t;

    localparam logic [3:0] OFS_PUSH = 4'd8;
    localparam logic [3:0] OFS_CFG  = 4'd9;

endpackage

// File: rtl/spi_pkt_fifo.sv
module spi_pkt_fifo #(
    parameter int DEPTH = 6,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          full, push_ok, pop_ok;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push_ok && !clr) begin
            mem[wr_ptr] <= din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) begin
                wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            end
            if (pop_ok) begin
                rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            end
            unique case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH)); // R4
    AST_FULL_PUSH_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !clr) |=> (count == $past(count))); // R4

endmodule

// File: rtl/spi_pkt_tick.sv
module spi_pkt_tick #(
    parameter int HALF = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = $clog2(HALF) + 1;

    logic [CW-1:0] cnt;

    assign tick = en && (cnt == CW'(HALF - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!en || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/spi_pkt_shift.sv
module spi_pkt_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_data,
    input  logic         tick,
    input  logic         miso,
    output logic         sclk,
    output logic         mosi,
    output logic [W-1:0] rx_data,
    output logic         done
);
    localparam int BW = $clog2(W);

    logic [W-1:0]  tx_sr, rx_sr;
    logic [BW-1:0] bitcnt;
    logic          active;

    assign mosi    = tx_sr[W-1];
    assign rx_data = rx_sr;
    assign done    = active && tick && sclk && (bitcnt == BW'(W - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sr  <= '0;
            rx_sr  <= '0;
            bitcnt <= '0;
            active <= 1'b0;
            sclk   <= 1'b0;
        end else if (load) begin
            tx_sr  <= load_data;
            bitcnt <= '0;
            active <= 1'b1;
            sclk   <= 1'b0;
        end else if (active && tick) begin
            if (!sclk) begin
                sclk  <= 1'b1;
                rx_sr <= {rx_sr[W-2:0], miso};
            end else begin
                sclk <= 1'b0;
                if (bitcnt == BW'(W - 1)) begin
                    active <= 1'b0;
                end else begin
                    bitcnt <= bitcnt + 1'b1;
                    tx_sr  <= {tx_sr[W-2:0], 1'b0};
                end
            end
        end
    end

    AST_SCLK_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk != $past(sclk)) |-> $past(tick)); // R3
    AST_MOSI_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi)); // R2

endmodule

// File: rtl/spi_pkt_master.sv
module spi_pkt_master
    import spi_pkt_pkg::*;
#(
    parameter int CLK_HZ     = 50_000_000,
    parameter int SCLK_HZ    = 5_000_000,
    parameter int FIFO_DEPTH = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_req,
    input  logic       bus_we,
    input  logic [3:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       bus_ready,
    output logic       spi_sclk,
    output logic       spi_mosi,
    input  logic       spi_miso,
    output logic       spi_cs_n,
    output logic [2:0] spi_sa
);
    localparam int HALF = (CLK_HZ / (2 * SCLK_HZ)) < 1 ? 1 : CLK_HZ / (2 * SCLK_HZ);
    localparam int W    = 8;

    pkt_state_t state, nxt;

    logic [2:0]   sa_q;
    logic         we_q;
    logic [W-1:0] data_q;
    logic         word_mode;
    logic [W-1:0] hi_q;
    logic [W-1:0] rdata_q;
    logic         cs_n_q;
    logic         in_final;
    logic         rx_more;

    logic         tick, tick_en;
    logic         start;
    logic         fifo_push, fifo_pop, fifo_clr, fifo_empty;
    logic [W-1:0] fifo_dout;
    logic         shift_load, shift_done;
    logic [W-1:0] shift_data, rx_byte;

    assign bus_ready = (state == ST_IDLE);
    assign bus_rdata = rdata_q;
    assign spi_cs_n  = cs_n_q;
    assign spi_sa    = sa_q;

    assign start      = bus_ready && bus_req && !bus_addr[3];
    assign fifo_push  = bus_ready && bus_req && bus_we && (bus_addr == OFS_PUSH);
    assign fifo_pop   = (state == ST_LOAD) && !fifo_empty;
    assign fifo_clr   = (state == ST_RELEASE) && tick;
    assign tick_en    = (state == ST_SETUP) || (state == ST_SHIFT) ||
                        (state == ST_HOLD)  || (state == ST_RELEASE);
    assign shift_load = (state == ST_LOAD);
    assign shift_data = !fifo_empty ? fifo_dout : (we_q ? data_q : '0);

    spi_pkt_fifo #(.DEPTH(FIFO_DEPTH), .W(W)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (fifo_clr),
        .push  (fifo_push),
        .din   (bus_wdata),
        .pop   (fifo_pop),
        .dout  (fifo_dout),
        .empty (fifo_empty)
    );

    spi_pkt_tick #(.HALF(HALF)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (tick_en),
        .tick  (tick)
    );

    spi_pkt_shift #(.W(W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (shift_load),
        .load_data (shift_data),
        .tick      (tick),
        .miso      (spi_miso),
        .sclk      (spi_sclk),
        .mosi      (spi_mosi),
        .rx_data   (rx_byte),
        .done      (shift_done)
    );

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (start) nxt = ST_SETUP;
            ST_SETUP:   if (tick) nxt = ST_LOAD;
            ST_LOAD:    nxt = ST_SHIFT;
            ST_SHIFT: begin
                if (shift_done) begin
                    if (!in_final || (!we_q && rx_more)) nxt = ST_LOAD;
                    else                                 nxt = ST_HOLD;
                end
            end
            ST_HOLD:    if (tick) nxt = ST_RELEASE;
            ST_RELEASE: if (tick) nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sa_q      <= '0;
            we_q      <= 1'b0;
            data_q    <= '0;
            word_mode <= 1'b0;
            hi_q      <= '0;
            rdata_q   <= '0;
            cs_n_q    <= 1'b1;
            in_final  <= 1'b0;
            rx_more   <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (bus_req) begin
                        if (!bus_addr[3]) begin
                            sa_q     <= bus_addr[2:0];
                            we_q     <= bus_we;
                            data_q   <= bus_wdata;
                            in_final <= 1'b0;
                            rx_more  <= 1'b0;
                        end else if (bus_we) begin
                            if (bus_addr == OFS_CFG) word_mode <= bus_wdata[0];
                        end else begin
                            rdata_q <= (bus_addr == OFS_PUSH) ? hi_q : '0;
                        end
                    end
                end
                ST_SETUP: begin
                    if (tick) cs_n_q <= 1'b0;
                end
                ST_LOAD: begin
                    if (fifo_empty && !in_final) begin
                        in_final <= 1'b1;
                        rx_more  <= !we_q && word_mode;
                    end
                end
                ST_SHIFT: begin
                    if (shift_done && in_final && !we_q) begin
                        if (rx_more) begin
                            hi_q    <= rx_byte;
                            rx_more <= 1'b0;
                        end else begin
                            rdata_q <= rx_byte;
                        end
                    end
                end
                ST_HOLD: begin
                    if (tick) cs_n_q <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    AST_CS_HIGH_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ready |-> spi_cs_n); // R1
    AST_SCLK_LOW_OUTSIDE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk); // R2
    AST_SA_HELD_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_cs_n |-> $stable(spi_sa)); // R10
    AST_REPLY_MOSI_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!spi_cs_n && in_final && !we_q) |-> !spi_mosi); // R6
    AST_QUEUE_EMPTY_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_ready) |-> fifo_empty); // R7
    AST_BUSY_PUSH_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_ready && bus_req) |-> !fifo_push); // R11

endmodule

// File: tb/sim_spi_pkt_master.sv
module sim_spi_pkt_master;
    localparam int CLK_PERIOD = 20;
    localparam int HALF_EXP   = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_req = 1'b0;
    logic       bus_we = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       bus_ready;
    logic       spi_sclk, spi_mosi, spi_cs_n;
    logic       spi_miso = 1'b0;
    logic [2:0] spi_sa;

    int tests = 0;
    int fails = 0;
    int cyc = 0;

    logic [7:0] mfifo[$];
    logic [7:0] exp_q[$];
    logic [7:0] slv_q[$];
    logic [7:0] mosi_q[$];
    logic       m_word = 1'b0;
    logic [2:0] exp_sa = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_pkt_master u0 (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ready(bus_ready), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso), .spi_cs_n(spi_cs_n), .spi_sa(spi_sa)
    );

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // behavioural slave and pin monitor, compared every clock
    logic       p_sclk = 1'b0, p_cs = 1'b1, p_ready = 1'b1;
    logic [7:0] cap = '0;
    int         ncap = 0, sbyte = 0, sbit = 7, hi_cnt = 0, pre_cnt = 0, post_cnt = 0;
    logic       seen_low = 1'b0;

    function automatic logic slv_bit(input int b, input int k);
        if (b < slv_q.size()) return slv_q[b][k];
        return 1'b0;
    endfunction

    always @(negedge clk) begin
        if (rst_n) begin
            if (spi_cs_n && spi_sclk) chk(1'b0, "R2 sclk high outside frame", 1, 0);
            if (!bus_ready && spi_sa != exp_sa) chk(1'b0, "R1 slave address", spi_sa, exp_sa);
            if (bus_ready && !spi_cs_n) chk(1'b0, "R1 cs low while ready", 0, 1);
            if (p_cs && !spi_cs_n) begin
                sbyte = 0; sbit = 7; ncap = 0;
                spi_miso <= slv_bit(0, 7);
                chk(pre_cnt >= HALF_EXP, "R10 address setup", pre_cnt, HALF_EXP);
                seen_low = 1'b1;
            end
            if (!bus_ready && spi_cs_n && !seen_low) pre_cnt++;
            if (!bus_ready && spi_cs_n && seen_low) post_cnt++;
            if (!spi_cs_n && !p_sclk && spi_sclk) begin
                cap = {cap[6:0], spi_mosi};
                ncap++;
                if (ncap % 8 == 0) mosi_q.push_back(cap);
            end
            if (spi_sclk) hi_cnt++;
            if (p_sclk && !spi_sclk) begin
                if (hi_cnt != HALF_EXP) chk(1'b0, "R3 sclk high time", hi_cnt, HALF_EXP);
                hi_cnt = 0;
                if (sbit == 0) begin sbit = 7; sbyte++; end
                else sbit--;
                spi_miso <= slv_bit(sbyte, sbit);
            end
            if (!p_ready && bus_ready) begin
                chk(post_cnt >= HALF_EXP, "R10 address hold", post_cnt, HALF_EXP);
                pre_cnt = 0; post_cnt = 0; seen_low = 1'b0;
            end
            p_sclk = spi_sclk; p_cs = spi_cs_n; p_ready = bus_ready;
        end
    end

    task automatic strobe(input logic we, input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0;
    endtask

    task automatic wait_ready();
        while (!bus_ready) @(negedge clk);
    endtask

    task automatic push(input logic [7:0] d);
        strobe(1'b1, 4'd8, d);
        if (mfifo.size() < 6) mfifo.push_back(d);
    endtask

    task automatic check_frame(input string tag);
        chk(mosi_q.size() == exp_q.size(), {tag, " frame length"}, mosi_q.size(), exp_q.size());
        if (mosi_q.size() == exp_q.size())
            foreach (exp_q[i]) chk(mosi_q[i] == exp_q[i], {tag, " frame byte"}, mosi_q[i], exp_q[i]);
    endtask

    task automatic xact(input logic we, input logic [2:0] off, input logic [7:0] d,
                        input logic [7:0] r0, input logic [7:0] r1, input string tag);
        exp_q.delete(); slv_q.delete(); mosi_q.delete();
        foreach (mfifo[i]) begin exp_q.push_back(mfifo[i]); slv_q.push_back(8'hA5); end
        if (we) exp_q.push_back(d);
        else begin
            exp_q.push_back(8'h00); slv_q.push_back(r0);
            if (m_word) begin exp_q.push_back(8'h00); slv_q.push_back(r1); end
        end
        mfifo.delete();
        exp_sa = off;
        strobe(we, {1'b0, off}, d);
        chk(!bus_ready, {tag, " busy after start"}, bus_ready, 0);
        wait_ready();
        check_frame(tag);
        if (!we) chk(bus_rdata == (m_word ? r1 : r0), {tag, " read data"}, bus_rdata, m_word ? r1 : r0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        chk(bus_ready == 1'b1, "R11 ready after reset", bus_ready, 1);
        chk(spi_cs_n == 1'b1, "R1 cs idle", spi_cs_n, 1);
        chk(spi_sclk == 1'b0, "R2 sclk idle", spi_sclk, 0);
        chk(bus_rdata == 8'h00, "R6 rdata reset", bus_rdata, 0);

        xact(1'b1, 3'd3, 8'h5A, 8'h00, 8'h00, "R5 lone write");
        push(8'h11); push(8'h22);
        xact(1'b1, 3'd5, 8'h33, 8'h00, 8'h00, "R5 queued write");
        xact(1'b1, 3'd5, 8'h44, 8'h00, 8'h00, "R7 queue cleared");
        for (int i = 1; i <= 7; i++) push(8'(i));
        xact(1'b1, 3'd0, 8'hEE, 8'h00, 8'h00, "R4 full queue");
        xact(1'b0, 3'd6, 8'h00, 8'hC3, 8'h00, "R8 default byte read");
        push(8'h9F);
        xact(1'b0, 3'd2, 8'h00, 8'h81, 8'h00, "R6 command then read");

        strobe(1'b1, 4'd9, 8'h01); m_word = 1'b1;
        push(8'h0B);
        xact(1'b0, 3'd7, 8'h00, 8'hBE, 8'hEF, "R9 word read");
        strobe(1'b0, 4'd8, 8'h00);
        chk(bus_rdata == 8'hBE, "R9 high byte at offset 8", bus_rdata, 8'hBE);

        // strobes during a busy frame must be ignored
        exp_q.delete(); slv_q.delete(); mosi_q.delete();
        exp_q.push_back(8'h77);
        exp_sa = 3'd1;
        strobe(1'b1, 4'd1, 8'h77);
        repeat (20) @(negedge clk);
        strobe(1'b1, 4'd8, 8'h55);
        strobe(1'b1, 4'd6, 8'h99);
        wait_ready();
        check_frame("R11 busy strobes");
        xact(1'b1, 3'd4, 8'h66, 8'h00, 8'h00, "R11 no stray push");

        strobe(1'b1, 4'd9, 8'h00); m_word = 1'b0;
        xact(1'b0, 3'd1, 8'h00, 8'h3C, 8'h00, "R8 word mode off");

        repeat (5) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            tests++; fails++;
            $display("FAIL watchdog R1 act=%0d exp=%0d", cyc, 100000);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule